// File: doc/BRIEF.md
# Snooping MSI Cache Line Controller

This block is the coherence engine for one private cache in a shared-bus multiprocessor. It holds a small direct-mapped array in which each slot carries a tag, one data word and a coherence state of Modified, Shared or Invalid. Processor reads and writes are served from that array when the state allows it. Otherwise the block requests the shared bus and issues a read miss, a write miss or a data-less upgrade. When the transaction completes, the line is installed.

The block also watches transactions that other caches place on the bus. In the same cycle it supplies data for a line it holds Modified, invalidates lines that another cache is about to write, and downgrades a Modified line to Shared on a remote read. A downgrade on a remote read and the eviction of a Modified victim are written back through a separate memory port. A remote write miss takes the line over without a writeback. Snoops take priority over processor requests.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready_o`, `bus_req_o` and `mem_wb_valid_o` are low, and a bus request is raised only after a processor request has been presented.
- R2: A read that misses raises a request with `bus_op_o` = 01 (read miss). It returns `bus_rdata_i` in the completion cycle and installs the line Shared, so a repeat read hits without bus activity.
- R3: A write to a Shared line raises `bus_op_o` = 11 (upgrade). On completion the line becomes Modified and holds the write data.
- R4: A read or write to a Modified line completes with `cpu_ready_o` in the cycle it is presented and raises no bus request. A read to a Shared line behaves the same way.
- R5: A write that misses raises `bus_op_o` = 10 (write miss) and installs the line Modified with the write data.
- R6: A snooped read miss (`snoop_op_i` = 01) to a Modified line drives `snoop_hit_m_o` and `snoop_data_o` in the same cycle. In that cycle it writes the line back on the memory port and leaves the line Shared.
- R7: A snooped write miss (`snoop_op_i` = 10) to a Modified line drives `snoop_hit_m_o` and the data with no memory writeback, and leaves the line Invalid.
- R8: A snooped upgrade (11) or write miss to a Shared line invalidates it without asserting `snoop_hit_m_o`.
- R9: A miss whose slot holds a different Modified line writes that victim (address and data) back in the cycle the request is accepted. A Shared victim is dropped with no writeback.
- R10: A matching snooped upgrade or write miss that arrives while the block's own upgrade waits for a grant turns the pending request into a write miss (10).
- R11: In a cycle with `snoop_valid_i` high, no processor request completes. The request completes in a later cycle.
- R12: `bus_op_o` is 00 while no transaction is pending, and `bus_req_o` is high from the cycle after acceptance until the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Processor request present, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready |
| bus_req_o | output | 1 | Request to the bus arbiter |
| bus_gnt_i | input | 1 | Grant; transaction starts this cycle |
| bus_op_o | output | 2 | 00 none, 01 read miss, 10 write miss, 11 upgrade |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_done_i | input | 1 | Own transaction completes |
| bus_rdata_i | input | DATA_W | Fill data at completion |
| snoop_valid_i | input | 1 | Another cache's transaction is on the bus |
| snoop_op_i | input | 2 | Snooped operation, same encoding as bus_op_o |
| snoop_addr_i | input | ADDR_W | Snooped address |
| snoop_hit_m_o | output | 1 | Line held Modified; memory must not respond |
| snoop_data_o | output | DATA_W | Data supplied to the requester |
| mem_wb_valid_o | output | 1 | Writeback to memory this cycle |
| mem_wb_addr_o | output | ADDR_W | Writeback address |
| mem_wb_data_o | output | DATA_W | Writeback data |

## Verification
The checks assume the following about the environment:
- The processor holds its address, direction and data steady from the cycle it raises `cpu_valid_i` until `cpu_ready_o`.
- The bus never shows a snoop in the same cycle as the block's own grant, or while its own transaction is in flight.
- A snooped upgrade never targets a line this cache holds Modified.

The directed stimulus respects all of these. It drives grants, completions and snoops only in the windows where the single-master bus would allow them. The one deliberate overlap, a snoop while the block's own request waits for a grant, is exactly the case the protocol permits.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {ST_I = 2'b00, ST_S = 2'b01, ST_M = 2'b10} line_st_e;
  typedef enum logic [1:0] {OP_NONE = 2'b00, OP_RD = 2'b01, OP_WR = 2'b10, OP_UPG = 2'b11} bus_op_e;
  typedef enum logic [1:0] {CS_IDLE, CS_REQ, CS_WAIT} ctl_st_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output logic [TAG_W-1:0]  ra_tag_o,
  output line_st_e          ra_st_o,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic [TAG_W-1:0]  rb_tag_o,
  output line_st_e          rb_st_o,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  w_idx_i,
  input  logic [TAG_W-1:0]  w_tag_i,
  input  line_st_e          w_st_i,
  input  logic [DATA_W-1:0] w_data_i
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (we_i) begin
      st_q[w_idx_i]   <= w_st_i;
      tag_q[w_idx_i]  <= w_tag_i;
      data_q[w_idx_i] <= w_data_i;
    end
  end

  assign ra_tag_o  = tag_q[ra_idx_i];
  assign ra_st_o   = st_q[ra_idx_i];
  assign ra_data_o = data_q[ra_idx_i];
  assign rb_tag_o  = tag_q[rb_idx_i];
  assign rb_st_o   = st_q[rb_idx_i];
  assign rb_data_o = data_q[rb_idx_i];
endmodule

// File: rtl/msi_snoop_resp.sv
module msi_snoop_resp
  import msi_pkg::*;
(
  input  logic     snp_valid_i,
  input  bus_op_e  snp_op_i,
  input  logic     tag_match_i,
  input  line_st_e line_st_i,
  output logic     upd_o,
  output line_st_e nxt_st_o,
  output logic     hit_m_o,
  output logic     wb_o
);
  logic present;
  assign present = snp_valid_i && tag_match_i && (line_st_i != ST_I);

  always_comb begin
    upd_o    = 1'b0;
    nxt_st_o = line_st_i;
    hit_m_o  = 1'b0;
    wb_o     = 1'b0;
    if (present) begin
      unique case (snp_op_i)
        OP_RD: if (line_st_i == ST_M) begin
          upd_o    = 1'b1;
          nxt_st_o = ST_S;
          hit_m_o  = 1'b1;
          wb_o     = 1'b1;
        end
        OP_WR: begin
          upd_o    = 1'b1;
          nxt_st_o = ST_I;
          hit_m_o  = (line_st_i == ST_M);
        end
        OP_UPG: begin
          upd_o    = 1'b1;
          nxt_st_o = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_done_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snoop_valid_i,
  input  logic [1:0]        snoop_op_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              snoop_hit_m_o,
  output logic [DATA_W-1:0] snoop_data_o,
  output logic              mem_wb_valid_o,
  output logic [ADDR_W-1:0] mem_wb_addr_o,
  output logic [DATA_W-1:0] mem_wb_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  idx_c, idx_s;
  logic [TAG_W-1:0]  tag_c, tag_s;
  logic [TAG_W-1:0]  a_tag, b_tag;
  line_st_e          a_st, b_st;
  logic [DATA_W-1:0] a_data, b_data;

  assign idx_c = cpu_addr_i[IDX_W-1:0];
  assign tag_c = cpu_addr_i[ADDR_W-1:IDX_W];
  assign idx_s = snoop_addr_i[IDX_W-1:0];
  assign tag_s = snoop_addr_i[ADDR_W-1:IDX_W];

  logic              we;
  logic [IDX_W-1:0]  w_idx;
  logic [TAG_W-1:0]  w_tag;
  line_st_e          w_st;
  logic [DATA_W-1:0] w_data;

  msi_line_store #(.TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) store_i (
    .clk_i, .rst_ni,
    .ra_idx_i(idx_c), .ra_tag_o(a_tag), .ra_st_o(a_st), .ra_data_o(a_data),
    .rb_idx_i(idx_s), .rb_tag_o(b_tag), .rb_st_o(b_st), .rb_data_o(b_data),
    .we_i(we), .w_idx_i(w_idx), .w_tag_i(w_tag), .w_st_i(w_st), .w_data_i(w_data)
  );

  logic     snp_upd, snp_hit_m, snp_wb;
  line_st_e snp_nxt;

  msi_snoop_resp snoop_i (
    .snp_valid_i(snoop_valid_i), .snp_op_i(bus_op_e'(snoop_op_i)),
    .tag_match_i(b_tag == tag_s), .line_st_i(b_st),
    .upd_o(snp_upd), .nxt_st_o(snp_nxt), .hit_m_o(snp_hit_m), .wb_o(snp_wb)
  );

  ctl_st_e st_q, st_d;
  bus_op_e op_q, op_d;
  logic    cpu_hit, snp_same;

  assign cpu_hit  = (a_st != ST_I) && (a_tag == tag_c);
  assign snp_same = snoop_valid_i && (snoop_addr_i == cpu_addr_i) &&
                    (bus_op_e'(snoop_op_i) inside {OP_WR, OP_UPG});

  always_comb begin
    st_d           = st_q;
    op_d           = op_q;
    cpu_ready_o    = 1'b0;
    we             = snp_upd;
    w_idx          = idx_s;
    w_tag          = b_tag;
    w_st           = snp_nxt;
    w_data         = b_data;
    mem_wb_valid_o = snp_wb;
    mem_wb_addr_o  = snp_wb ? snoop_addr_i : '0;
    mem_wb_data_o  = snp_wb ? b_data : '0;
    unique case (st_q)
      CS_IDLE: if (cpu_valid_i && !snoop_valid_i) begin
        if (cpu_hit && (!cpu_we_i || a_st == ST_M)) begin
          cpu_ready_o = 1'b1;
          if (cpu_we_i) begin
            we = 1'b1; w_idx = idx_c; w_tag = a_tag; w_st = ST_M; w_data = cpu_wdata_i;
          end
        end else if (cpu_hit) begin
          op_d = OP_UPG;
          st_d = CS_REQ;
        end else begin
          op_d = cpu_we_i ? OP_WR : OP_RD;
          st_d = CS_REQ;
          if (a_st == ST_M) begin  // dirty victim leaves now
            mem_wb_valid_o = 1'b1;
            mem_wb_addr_o  = {a_tag, idx_c};
            mem_wb_data_o  = a_data;
            we = 1'b1; w_idx = idx_c; w_tag = a_tag; w_st = ST_I; w_data = a_data;
          end
        end
      end
      CS_REQ: begin
        if (snoop_valid_i) begin
          if (op_q == OP_UPG && snp_same) op_d = OP_WR;
        end else if (bus_gnt_i) begin
          st_d = CS_WAIT;
        end
      end
      CS_WAIT: if (bus_done_i) begin
        cpu_ready_o = 1'b1;
        st_d        = CS_IDLE;
        op_d        = OP_NONE;
        we          = 1'b1;
        w_idx       = idx_c;
        w_tag       = tag_c;
        w_st        = (op_q == OP_RD) ? ST_S : ST_M;
        w_data      = cpu_we_i ? cpu_wdata_i : bus_rdata_i;
      end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= CS_IDLE;
      op_q <= OP_NONE;
    end else begin
      st_q <= st_d;
      op_q <= op_d;
    end
  end

  assign bus_req_o     = (st_q == CS_REQ);
  assign bus_op_o      = (st_q == CS_IDLE) ? OP_NONE : op_q;
  assign bus_addr_o    = (st_q == CS_IDLE) ? '0 : cpu_addr_i;
  assign cpu_rdata_o   = (st_q == CS_WAIT) ? bus_rdata_i : a_data;
  assign snoop_hit_m_o = snp_hit_m;
  assign snoop_data_o  = snp_hit_m ? b_data : '0;
endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_valid_i,
  input logic              cpu_ready_o,
  input logic              bus_req_o,
  input logic [1:0]        bus_op_o,
  input logic              bus_done_i,
  input logic              snoop_valid_i,
  input logic [1:0]        snoop_op_i,
  input logic [ADDR_W-1:0] snoop_addr_i,
  input logic              snoop_hit_m_o,
  input logic [DATA_W-1:0] snoop_data_o,
  input logic              mem_wb_valid_o,
  input logic [ADDR_W-1:0] mem_wb_addr_o,
  input logic [DATA_W-1:0] mem_wb_data_o
);
  // R1
  req_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(cpu_valid_i));
  // R12
  req_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_op_o != 2'b00);
  // R4
  hit_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o && !bus_done_i |-> !bus_req_o && bus_op_o == 2'b00);
  // R6
  dgrade_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_hit_m_o && snoop_op_i == 2'b01 |->
      mem_wb_valid_o && mem_wb_addr_o == snoop_addr_i && mem_wb_data_o == snoop_data_o);
  // R7
  no_wb_on_wm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_valid_i && snoop_op_i == 2'b10 |-> !mem_wb_valid_o);
  // R8
  upg_no_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_valid_i && snoop_op_i == 2'b11 |-> !snoop_hit_m_o);
  // R11
  snoop_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_valid_i && !bus_done_i |-> !cpu_ready_o);
  // R6
  hit_m_needs_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_hit_m_o |-> snoop_valid_i);
endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_valid_i(cpu_valid_i), .cpu_ready_o(cpu_ready_o),
  .bus_req_o(bus_req_o), .bus_op_o(bus_op_o), .bus_done_i(bus_done_i),
  .snoop_valid_i(snoop_valid_i), .snoop_op_i(snoop_op_i), .snoop_addr_i(snoop_addr_i),
  .snoop_hit_m_o(snoop_hit_m_o), .snoop_data_o(snoop_data_o),
  .mem_wb_valid_o(mem_wb_valid_o), .mem_wb_addr_o(mem_wb_addr_o), .mem_wb_data_o(mem_wb_data_o)
);

// File: tb/msi_line_ctrl_tb.sv
module msi_line_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_ADDR = 8'h10, B_ADDR = 8'h14, C_ADDR = 8'h21, D_ADDR = 8'h22;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 0, cpu_we = 0, bus_gnt = 0, bus_done = 0, snoop_valid = 0;
  logic [7:0] cpu_addr = 0, snoop_addr = 0;
  logic [15:0] cpu_wdata = 0, bus_rdata = 0;
  logic [1:0] snoop_op = 0;
  logic cpu_ready_o, bus_req_o, snoop_hit_m_o, mem_wb_valid_o;
  logic [15:0] cpu_rdata_o, snoop_data_o, mem_wb_data_o;
  logic [1:0] bus_op_o;
  logic [7:0] bus_addr_o, mem_wb_addr_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_line_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_valid_i(cpu_valid), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_ready_o, .cpu_rdata_o,
    .bus_req_o, .bus_gnt_i(bus_gnt), .bus_op_o, .bus_addr_o, .bus_done_i(bus_done),
    .bus_rdata_i(bus_rdata), .snoop_valid_i(snoop_valid), .snoop_op_i(snoop_op),
    .snoop_addr_i(snoop_addr), .snoop_hit_m_o, .snoop_data_o,
    .mem_wb_valid_o, .mem_wb_addr_o, .mem_wb_data_o
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cpu_access(input logic we, input logic [7:0] a, input logic [15:0] wd,
                            input logic [15:0] fill, output logic [1:0] op,
                            output logic [15:0] rd, output logic wbv,
                            output logic [7:0] wba, output logic [15:0] wbd);
    @(negedge clk);
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    wbv = mem_wb_valid_o; wba = mem_wb_addr_o; wbd = mem_wb_data_o;
    if (cpu_ready_o) begin
      op = 2'b00; rd = cpu_rdata_o;
      @(negedge clk);
    end else begin
      @(negedge clk); #1;
      op = bus_op_o;
      chk("R12 request raised", 32'(bus_req_o), 32'd1);
      bus_gnt = 1;
      @(negedge clk);
      bus_gnt = 0; bus_done = 1; bus_rdata = fill;
      #1;
      chk("R12 completion ready", 32'(cpu_ready_o), 32'd1);
      rd = cpu_rdata_o;
      @(negedge clk);
    end
    cpu_valid = 0; bus_done = 0;
  endtask

  task automatic snoop(input logic [1:0] op, input logic [7:0] a, output logic hm,
                       output logic [15:0] sd, output logic wbv, output logic [7:0] wba,
                       output logic [15:0] wbd);
    @(negedge clk);
    snoop_valid = 1; snoop_op = op; snoop_addr = a;
    #1;
    hm = snoop_hit_m_o; sd = snoop_data_o;
    wbv = mem_wb_valid_o; wba = mem_wb_addr_o; wbd = mem_wb_data_o;
    @(negedge clk);
    snoop_valid = 0;
  endtask

  logic [1:0] op; logic [15:0] rd, sd, wbd; logic wbv, hm; logic [7:0] wba;

  task automatic t_reset();
    #1;
    chk("R1 ready low", 32'(cpu_ready_o), 32'd0);
    chk("R1 req low", 32'(bus_req_o), 32'd0);
    chk("R1 wb low", 32'(mem_wb_valid_o), 32'd0);
    chk("R12 op none", 32'(bus_op_o), 32'd0);
  endtask

  task automatic t_read_miss();
    cpu_access(0, A_ADDR, 0, 16'h1111, op, rd, wbv, wba, wbd);
    chk("R2 op read miss", 32'(op), 32'd1);
    chk("R2 data", 32'(rd), 32'h1111);
    chk("R1 first access no wb", 32'(wbv), 32'd0);
    cpu_access(0, A_ADDR, 0, 16'hdead, op, rd, wbv, wba, wbd);
    chk("R2 repeat hit no bus", 32'(op), 32'd0);
    chk("R2 repeat data", 32'(rd), 32'h1111);
    chk("R12 idle op", 32'(bus_op_o), 32'd0);
  endtask

  task automatic t_upgrade_hits();
    cpu_access(1, A_ADDR, 16'h2222, 0, op, rd, wbv, wba, wbd);
    chk("R3 op upgrade", 32'(op), 32'd3);
    cpu_access(0, A_ADDR, 0, 16'hdead, op, rd, wbv, wba, wbd);
    chk("R4 read M no bus", 32'(op), 32'd0);
    chk("R3 data after upgrade", 32'(rd), 32'h2222);
    cpu_access(1, A_ADDR, 16'h3333, 0, op, rd, wbv, wba, wbd);
    chk("R4 write M no bus", 32'(op), 32'd0);
  endtask

  task automatic t_snoop_rd_m();
    snoop(2'b01, A_ADDR, hm, sd, wbv, wba, wbd);
    chk("R6 hit_m", 32'(hm), 32'd1);
    chk("R6 supplied data", 32'(sd), 32'h3333);
    chk("R6 wb valid", 32'(wbv), 32'd1);
    chk("R6 wb addr", 32'(wba), 32'(A_ADDR));
    chk("R6 wb data", 32'(wbd), 32'h3333);
    cpu_access(1, A_ADDR, 16'h4444, 0, op, rd, wbv, wba, wbd);
    chk("R6 now Shared so upgrade", 32'(op), 32'd3);
  endtask

  task automatic t_snoop_wr_m();
    snoop(2'b10, A_ADDR, hm, sd, wbv, wba, wbd);
    chk("R7 hit_m", 32'(hm), 32'd1);
    chk("R7 supplied data", 32'(sd), 32'h4444);
    chk("R7 no wb", 32'(wbv), 32'd0);
    cpu_access(0, A_ADDR, 0, 16'h5555, op, rd, wbv, wba, wbd);
    chk("R7 now Invalid so read miss", 32'(op), 32'd1);
    chk("R7 refill data", 32'(rd), 32'h5555);
  endtask

  task automatic t_snoop_on_s();
    snoop(2'b11, A_ADDR, hm, sd, wbv, wba, wbd);
    chk("R8 upgrade no hit_m", 32'(hm), 32'd0);
    chk("R8 upgrade no wb", 32'(wbv), 32'd0);
    cpu_access(0, A_ADDR, 0, 16'h6666, op, rd, wbv, wba, wbd);
    chk("R8 invalid after upgrade", 32'(op), 32'd1);
    snoop(2'b10, A_ADDR, hm, sd, wbv, wba, wbd);
    chk("R8 write miss no hit_m", 32'(hm), 32'd0);
    cpu_access(0, A_ADDR, 0, 16'h6767, op, rd, wbv, wba, wbd);
    chk("R8 invalid after write miss", 32'(op), 32'd1);
  endtask

  task automatic t_evict();
    cpu_access(1, A_ADDR, 16'h7777, 0, op, rd, wbv, wba, wbd);
    cpu_access(0, B_ADDR, 0, 16'h8888, op, rd, wbv, wba, wbd);
    chk("R9 dirty victim wb", 32'(wbv), 32'd1);
    chk("R9 victim addr", 32'(wba), 32'(A_ADDR));
    chk("R9 victim data", 32'(wbd), 32'h7777);
    chk("R9 miss op", 32'(op), 32'd1);
    cpu_access(0, A_ADDR, 0, 16'h9999, op, rd, wbv, wba, wbd);
    chk("R9 shared victim dropped", 32'(wbv), 32'd0);
    chk("R9 refill data", 32'(rd), 32'h9999);
  endtask

  task automatic t_write_miss();
    cpu_access(1, C_ADDR, 16'haaaa, 16'hbbbb, op, rd, wbv, wba, wbd);
    chk("R5 op write miss", 32'(op), 32'd2);
    cpu_access(0, C_ADDR, 0, 16'hdead, op, rd, wbv, wba, wbd);
    chk("R5 installed Modified hit", 32'(op), 32'd0);
    chk("R5 write data kept", 32'(rd), 32'haaaa);
  endtask

  task automatic t_convert();
    cpu_access(0, D_ADDR, 0, 16'h0c0c, op, rd, wbv, wba, wbd);
    @(negedge clk);
    cpu_valid = 1; cpu_we = 1; cpu_addr = D_ADDR; cpu_wdata = 16'hd00d;
    @(negedge clk); #1;
    chk("R10 initial upgrade", 32'(bus_op_o), 32'd3);
    snoop_valid = 1; snoop_op = 2'b11; snoop_addr = D_ADDR;
    #1;
    chk("R10 snoop no hit_m", 32'(snoop_hit_m_o), 32'd0);
    @(negedge clk);
    snoop_valid = 0;
    #1;
    chk("R10 converted to write miss", 32'(bus_op_o), 32'd2);
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0; bus_done = 1; bus_rdata = 16'h0e0e;
    #1;
    chk("R10 completes", 32'(cpu_ready_o), 32'd1);
    @(negedge clk);
    cpu_valid = 0; bus_done = 0;
    cpu_access(0, D_ADDR, 0, 16'hdead, op, rd, wbv, wba, wbd);
    chk("R10 line Modified", 32'(op), 32'd0);
    chk("R10 write data", 32'(rd), 32'hd00d);
  endtask

  task automatic t_priority();
    @(negedge clk);
    cpu_valid = 1; cpu_we = 0; cpu_addr = A_ADDR;
    snoop_valid = 1; snoop_op = 2'b01; snoop_addr = C_ADDR;
    #1;
    chk("R11 cpu stalled", 32'(cpu_ready_o), 32'd0);
    chk("R11 snoop served", 32'(snoop_hit_m_o), 32'd1);
    chk("R6 snoop data", 32'(snoop_data_o), 32'haaaa);
    @(negedge clk);
    snoop_valid = 0;
    #1;
    chk("R11 cpu after snoop", 32'(cpu_ready_o), 32'd1);
    chk("R11 data", 32'(cpu_rdata_o), 32'h9999);
    @(negedge clk);
    cpu_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_read_miss();
    t_upgrade_hits();
    t_snoop_rd_m();
    t_snoop_wr_m();
    t_snoop_on_s();
    t_evict();
    t_write_miss();
    t_convert();
    t_priority();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule